// File: doc/BRIEF.md
# Predicated Instruction Field Decoder

This block is one registered decode stage for a 32-bit instruction word of a VLIW-style signal-processing core. It slices the word into three register indices, an opcode, a register-file side select and a parallel-issue bit. Every instruction carries a condition-register selector and an invert bit, so the stage also resolves the predicate. It compares the selected condition register with zero and outputs a single execute-enable flag that later stages can use directly.

A word is presented with `in_valid` together with the current contents of the condition-capable registers. The decoded result appears on the next clock edge with `out_valid`. Condition codes that are reserved, or that the configuration does not support, block execution and raise an illegal-condition flag. The parameter `ALLOW_A0` chooses whether register A0 may act as a condition. One known opcode pattern, the signed-integer add on the data unit, gets its own flag.

Top module: `pred_field_decoder`

## Requirements
- R1: Field positions are: condition code in bits 31:29, invert bit in bit 28, destination in 27:23, source 2 in 22:18, source 1 in 17:13, opcode in 12:7, unit-format field in 6:2, side select in bit 1 and parallel bit in bit 0. Word 0x02148842 decodes to dst=4, src2=5, src1=4, opcode=0x10, side=1, par=0.
- R2: The outputs of a word accepted with `in_valid` appear on the following rising edge with `out_valid` high. In a cycle after `in_valid` was low, `out_valid` is low and every decoded output keeps its previous value.
- R3: While reset is asserted (active low) and directly after it, every output is zero.
- R4: Condition code 000 with the invert bit clear means unconditional: `exec_en`=1 and `illegal_cond`=0, whatever the register values are.
- R5: Condition codes select registers as follows: 001=B0, 010=B1, 011=B2, 100=A1, 101=A2. With the invert bit clear, `exec_en` is 1 exactly when the selected register is nonzero.
- R6: With the invert bit set and a supported code, `exec_en` is 1 exactly when the selected register is zero.
- R7: When `ALLOW_A0`=1 (the default), code 110 selects A0 and follows R5/R6.
- R8: Code 111, code 000 with the invert bit set, and code 110 when `ALLOW_A0`=0 are reserved. For these, `illegal_cond`=1 and `exec_en`=0.
- R9: `add_sint` is 1 exactly when the opcode is 010000 and the unit-format field (bits 6:2) is 10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| cond_a0 | input | DATA_W | Current value of A0 |
| cond_a1 | input | DATA_W | Current value of A1 |
| cond_a2 | input | DATA_W | Current value of A2 |
| cond_b0 | input | DATA_W | Current value of B0 |
| cond_b1 | input | DATA_W | Current value of B1 |
| cond_b2 | input | DATA_W | Current value of B2 |
| out_valid | output | 1 | Decoded outputs updated this cycle |
| dst_idx | output | 5 | Destination register index |
| src2_idx | output | 5 | Source 2 register index |
| src1_idx | output | 5 | Source 1 register index |
| opcode | output | 6 | Opcode field |
| side_b | output | 1 | 1 selects the B register file |
| par_next | output | 1 | Parallel-issue bit |
| exec_en | output | 1 | Predicate passed, instruction may execute |
| illegal_cond | output | 1 | Reserved or unsupported condition code |
| add_sint | output | 1 | Signed-integer add on the data unit |

## Verification
The stage holds only one register of decoded results, so any wrong internal value shows at the ports on the edge right after the word is accepted. A mis-wired register mux shows up as an inverted `exec_en` when only the selected register is zero and all the other registers are nonzero, or the other way round. A wrong field slice shows up as wrong indices on the reference word. A flaw in the hold logic shows up one idle cycle later, as changed outputs or a stuck `out_valid`. Each reserved code is tried with registers that would otherwise pass, so a missing guard shows up as `exec_en` high.

// File: rtl/pred_field_decoder.sv
module pred_field_decoder #(
  parameter int DATA_W   = 32,
  parameter bit ALLOW_A0 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] cond_a0,
  input  logic [DATA_W-1:0] cond_a1,
  input  logic [DATA_W-1:0] cond_a2,
  input  logic [DATA_W-1:0] cond_b0,
  input  logic [DATA_W-1:0] cond_b1,
  input  logic [DATA_W-1:0] cond_b2,
  output logic              out_valid,
  output logic [4:0]        dst_idx,
  output logic [4:0]        src2_idx,
  output logic [4:0]        src1_idx,
  output logic [5:0]        opcode,
  output logic              side_b,
  output logic              par_next,
  output logic              exec_en,
  output logic              illegal_cond,
  output logic              add_sint
);

  localparam logic [5:0] OP_ADD_SINT = 6'b010000;
  localparam logic [4:0] FMT_DUNIT   = 5'b10000;

  logic [2:0]        creg;
  logic              inv;
  logic [DATA_W-1:0] sel_val;
  logic              code_ok;
  logic              pass;

  assign creg = instr[31:29];
  assign inv  = instr[28];

  always_comb begin
    sel_val = '0;
    code_ok = 1'b1;
    case (creg)
      3'b000: code_ok = ~inv;
      3'b001: sel_val = cond_b0;
      3'b010: sel_val = cond_b1;
      3'b011: sel_val = cond_b2;
      3'b100: sel_val = cond_a1;
      3'b101: sel_val = cond_a2;
      3'b110: begin
        sel_val = cond_a0;
        code_ok = ALLOW_A0;
      end
      default: code_ok = 1'b0;
    endcase
  end

  assign pass = (creg == 3'b000) ? 1'b1 : ((|sel_val) ^ inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      dst_idx      <= '0;
      src2_idx     <= '0;
      src1_idx     <= '0;
      opcode       <= '0;
      side_b       <= 1'b0;
      par_next     <= 1'b0;
      exec_en      <= 1'b0;
      illegal_cond <= 1'b0;
      add_sint     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_idx      <= instr[27:23];
        src2_idx     <= instr[22:18];
        src1_idx     <= instr[17:13];
        opcode       <= instr[12:7];
        side_b       <= instr[1];
        par_next     <= instr[0];
        exec_en      <= code_ok & pass;
        illegal_cond <= ~code_ok;
        add_sint     <= (instr[12:7] == OP_ADD_SINT) && (instr[6:2] == FMT_DUNIT);
      end
    end
  end

  a_r1_dst_field: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (dst_idx == $past(instr[27:23]) && src1_idx == $past(instr[17:13])));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dst_idx) && $stable(exec_en)));

  a_r4_unconditional: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:28] == 4'b0000) |=> (exec_en && !illegal_cond));

  a_r8_illegal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cond |-> !exec_en);

  a_r8_code7_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:29] == 3'b111) |=> illegal_cond);

  a_r9_add_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    add_sint |-> (opcode == OP_ADD_SINT));

endmodule

// File: tb/pred_field_decoder_test.sv
module pred_field_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [DW-1:0] ra0 = '0, ra1 = '0, ra2 = '0, rb0 = '0, rb1 = '0, rb2 = '0;

  logic out_valid, side_b, par_next, exec_en, illegal_cond, add_sint;
  logic [4:0] dst_idx, src2_idx, src1_idx;
  logic [5:0] opcode;
  logic n_valid, n_side, n_par, n_exec, n_ill, n_add;
  logic [4:0] n_dst, n_s2, n_s1;
  logic [5:0] n_op;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_field_decoder #(.DATA_W(DW), .ALLOW_A0(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .cond_a0(ra0), .cond_a1(ra1), .cond_a2(ra2),
    .cond_b0(rb0), .cond_b1(rb1), .cond_b2(rb2),
    .out_valid(out_valid), .dst_idx(dst_idx), .src2_idx(src2_idx),
    .src1_idx(src1_idx), .opcode(opcode), .side_b(side_b), .par_next(par_next),
    .exec_en(exec_en), .illegal_cond(illegal_cond), .add_sint(add_sint));

  pred_field_decoder #(.DATA_W(DW), .ALLOW_A0(1'b0)) uut_na (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .cond_a0(ra0), .cond_a1(ra1), .cond_a2(ra2),
    .cond_b0(rb0), .cond_b1(rb1), .cond_b2(rb2),
    .out_valid(n_valid), .dst_idx(n_dst), .src2_idx(n_s2),
    .src1_idx(n_s1), .opcode(n_op), .side_b(n_side), .par_next(n_par),
    .exec_en(n_exec), .illegal_cond(n_ill), .add_sint(n_add));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] c, input logic z, input logic [4:0] d,
      input logic [4:0] s2, input logic [4:0] s1, input logic [5:0] op,
      input logic [4:0] fx, input logic s, input logic p);
    return {c, z, d, s2, s1, op, fx, s, p};
  endfunction

  task automatic set_regs(input int code, input logic [DW-1:0] v);
    logic [DW-1:0] other;
    other = (v == 0) ? 32'h0000_0100 : '0;
    ra0 = other; ra1 = other; ra2 = other;
    rb0 = other; rb1 = other; rb2 = other;
    case (code)
      1: rb0 = v;
      2: rb1 = v;
      3: rb2 = v;
      4: ra1 = v;
      5: ra2 = v;
      6: ra0 = v;
      default: ;
    endcase
  endtask

  task automatic apply(input logic [31:0] w);
    instr = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R3 out_valid", {31'b0, out_valid}, 0);
    chk("R3 dst", {27'b0, dst_idx}, 0);
    chk("R3 exec_en", {31'b0, exec_en}, 0);
    chk("R3 illegal", {31'b0, illegal_cond}, 0);
    chk("R3 add_sint", {31'b0, add_sint}, 0);
  endtask

  task automatic t_reference_word;
    set_regs(0, 0);
    apply(32'h0214_8842);
    chk("R2 out_valid", {31'b0, out_valid}, 1);
    chk("R1 dst", {27'b0, dst_idx}, 4);
    chk("R1 src2", {27'b0, src2_idx}, 5);
    chk("R1 src1", {27'b0, src1_idx}, 4);
    chk("R1 opcode", {26'b0, opcode}, 6'h10);
    chk("R1 side", {31'b0, side_b}, 1);
    chk("R1 par", {31'b0, par_next}, 0);
    chk("R4 exec_en", {31'b0, exec_en}, 1);
    chk("R9 add_sint", {31'b0, add_sint}, 1);
    instr = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R2 idle valid", {31'b0, out_valid}, 0);
    chk("R2 idle dst hold", {27'b0, dst_idx}, 4);
    chk("R2 idle exec hold", {31'b0, exec_en}, 1);
    chk("R2 idle add hold", {31'b0, add_sint}, 1);
  endtask

  task automatic t_other_fields;
    apply(mk(3'b000, 1'b0, 5'd31, 5'd0, 5'd17, 6'h2A, 5'b00000, 1'b0, 1'b1));
    chk("R1 dst", {27'b0, dst_idx}, 31);
    chk("R1 src2", {27'b0, src2_idx}, 0);
    chk("R1 src1", {27'b0, src1_idx}, 17);
    chk("R1 opcode", {26'b0, opcode}, 6'h2A);
    chk("R1 side", {31'b0, side_b}, 0);
    chk("R1 par", {31'b0, par_next}, 1);
    chk("R9 other opcode", {31'b0, add_sint}, 0);
    apply(mk(3'b000, 1'b0, 5'd1, 5'd2, 5'd3, 6'b010000, 5'b10001, 1'b1, 1'b0));
    chk("R9 wrong format", {31'b0, add_sint}, 0);
    apply(mk(3'b000, 1'b0, 5'd1, 5'd2, 5'd3, 6'b010000, 5'b10000, 1'b0, 1'b0));
    chk("R9 add on side A", {31'b0, add_sint}, 1);
  endtask

  task automatic t_unconditional;
    set_regs(0, 0);
    ra0 = 0; ra1 = 0; ra2 = 0; rb0 = 0; rb1 = 0; rb2 = 0;
    apply(mk(3'b000, 1'b0, 5'd9, 5'd9, 5'd9, 6'h01, 5'b0, 1'b0, 1'b0));
    chk("R4 exec all zero", {31'b0, exec_en}, 1);
    chk("R4 not illegal", {31'b0, illegal_cond}, 0);
  endtask

  task automatic t_conditions;
    for (int code = 1; code <= 6; code++) begin
      for (int zi = 0; zi < 2; zi++) begin
        for (int nz = 0; nz < 2; nz++) begin
          logic expx;
          set_regs(code, nz ? 32'h8000_0000 : 32'h0);
          apply(mk(code[2:0], zi[0], 5'd2, 5'd3, 5'd4, 6'h05, 5'b0, 1'b0, 1'b0));
          expx = nz[0] ^ zi[0];
          if (code == 6) chk("R7 A0 exec", {31'b0, exec_en}, {31'b0, expx});
          else if (zi == 0) chk("R5 exec", {31'b0, exec_en}, {31'b0, expx});
          else chk("R6 exec", {31'b0, exec_en}, {31'b0, expx});
          chk("R5 not illegal", {31'b0, illegal_cond}, 0);
        end
      end
    end
  endtask

  task automatic t_reserved;
    set_regs(0, 0);
    ra0 = 0; ra1 = 0; ra2 = 0; rb0 = 0; rb1 = 0; rb2 = 0;
    apply(mk(3'b111, 1'b1, 5'd1, 5'd1, 5'd1, 6'h0, 5'b0, 1'b0, 1'b0));
    chk("R8 code7 illegal", {31'b0, illegal_cond}, 1);
    chk("R8 code7 exec", {31'b0, exec_en}, 0);
    ra0 = 1; ra1 = 1; ra2 = 1; rb0 = 1; rb1 = 1; rb2 = 1;
    apply(mk(3'b111, 1'b0, 5'd1, 5'd1, 5'd1, 6'h0, 5'b0, 1'b0, 1'b0));
    chk("R8 code7 z0 illegal", {31'b0, illegal_cond}, 1);
    chk("R8 code7 z0 exec", {31'b0, exec_en}, 0);
    apply(mk(3'b000, 1'b1, 5'd1, 5'd1, 5'd1, 6'h0, 5'b0, 1'b0, 1'b0));
    chk("R8 code0 z1 illegal", {31'b0, illegal_cond}, 1);
    chk("R8 code0 z1 exec", {31'b0, exec_en}, 0);
    apply(mk(3'b110, 1'b0, 5'd1, 5'd1, 5'd1, 6'h0, 5'b0, 1'b0, 1'b0));
    chk("R7 A0 allowed", {31'b0, illegal_cond}, 0);
    chk("R8 A0 disabled illegal", {31'b0, n_ill}, 1);
    chk("R8 A0 disabled exec", {31'b0, n_exec}, 0);
    chk("R8 A0 disabled fields", {27'b0, n_dst}, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reference_word();
    t_other_fields();
    t_unconditional();
    t_conditions();
    t_reserved();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule